// File: doc/BRIEF.md
# Buffered-Compare Interval Timer/Counter

This block is an 8-bit up-counter that raises a sticky match flag and an interrupt each time its count reaches a compare value, then starts over from zero. The count source is picked by a control bit. It can be a prescaled internal tick pulse, which makes the block an interval timer, or the rising edges of an external event line, which makes it an event counter. Software writes the compare value into a data register. The comparator does not look at that register directly. It compares against a separate latch, which is refilled from the register only when counting starts or when a match occurs. A new value therefore never shortens or stretches the period that is already running.

In interval use, a compare value of N gives one match every N+1 ticks. In event use, the same value is the number of events to detect, less one. The block can also act as the upper byte of a 16-bit counter. In that case it steps on the lower byte's wrap pulse, and it matches only when its own byte and the lower byte agree in the same cycle. A small register bus gives access to the data register, the control bits, the flag and the live count.

Top module: `bcit_timer`

## Requirements
- R1: `eq_out` is high exactly while the count equals the comparator latch, whatever the data register holds.
- R2: A write to the control register (address 1) that takes the run bit (bit 0) from 0 to 1 clears the count and loads the latch from the data register at that clock edge. A control write while run is already 1 neither clears the count nor reloads the latch.
- R3: Outside cascade mode, a count step that finds the count equal to the latch produces a match. The count goes to 0, the latch is reloaded and the flag is set at that edge. A latch value of N gives one match every N+1 steps.
- R4: A data register write (address 0) made while running leaves the latch unchanged until the next match or start.
- R5: With source bit (control bit 1) at 0, each cycle with `tick_in` high is a step. With source bit at 1, each rising edge of `ext_evt` is one step, however long the level is held, and `tick_in` is ignored.
- R6: While run is 0, the count holds its value whatever the step inputs do.
- R7: The flag (address 2 bit 0) stays set until software writes bit 0 as 0. Writing 1 has no effect. A match in the same cycle as a clearing write leaves the flag set. `irq` is high exactly while the flag and the interrupt enable (control bit 3) are both 1.
- R8: In cascade mode (control bit 2 = 1), the count steps on `casc_wrap_in` and ignores its own sources. A match happens only on a `casc_tick_in` cycle in which the count equals the latch and `casc_eq_in` is high.
- R9: `wrap_out` is high in a cycle in which a step takes the count from 255 to 0 without a match. The count is 0 after that edge.
- R10: Reads return the data register at address 0, {enable, cascade, source, run} in bits 3..0 at address 1, the flag in bit 0 at address 2, and the live count at address 3. Writes to address 3 are ignored. After reset, the control bits, flag, count and latch are 0. The data register's reset value is not to be relied on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tick_in | input | 1 | Prescaled internal count pulse |
| ext_evt | input | 1 | External event level, rising edges counted |
| casc_tick_in | input | 1 | Lower byte's step pulse, cascade mode |
| casc_wrap_in | input | 1 | Lower byte's wrap pulse, cascade mode |
| casc_eq_in | input | 1 | Lower byte equals its compare, cascade mode |
| irq | output | 1 | Interrupt request |
| eq_out | output | 1 | Count equals comparator latch |
| wrap_out | output | 1 | Count wraps from all ones to zero this cycle |

## Verification
Count, latch, flag and control take their new values at the first rising edge after the cycle in which a step, a match or a bus write is presented. `irq` and `eq_out` follow combinationally from those registers. `bus_rdata` and `wrap_out` are combinational from the registers and the present inputs, so they are valid in the same cycle as the stimulus. The bench therefore changes inputs on the falling edge and applies each cycle to its model at the rising edge. It compares every output 1 ns after the following falling edge, which lets the rising edge that carries a stimulus's effect land before anything is sampled.

// File: rtl/bcit_pkg.sv
package bcit_pkg;

    localparam int unsigned BUS_AW = 2;

    localparam logic [BUS_AW-1:0] ADR_DATA  = 2'd0;
    localparam logic [BUS_AW-1:0] ADR_CTRL  = 2'd1;
    localparam logic [BUS_AW-1:0] ADR_FLAG  = 2'd2;
    localparam logic [BUS_AW-1:0] ADR_COUNT = 2'd3;

    // control bits, MSB first: enable, cascade, source, run
    typedef struct packed {
        logic irq_en;
        logic cascade;
        logic ext_src;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/bcit_regs.sv
module bcit_regs
    import bcit_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              match_i,
    input  logic [W-1:0]      count_i,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      data_o,
    output ctrl_t             ctrl_o,
    output logic              flag_o,
    output logic              start_rise_o
);

    typedef struct packed {
        logic [W-1:0] data;
        ctrl_t        ctrl;
        logic         flag;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_en;

    always_comb begin
        s_d          = s_q;
        wr_en        = bus_sel && bus_wr;
        start_rise_o = 1'b0;
        if (wr_en) begin
            case (bus_addr)
                ADR_DATA: s_d.data = bus_wdata;
                ADR_CTRL: begin
                    s_d.ctrl     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    start_rise_o = bus_wdata[0] && !s_q.ctrl.run;
                end
                ADR_FLAG: begin
                    if (!bus_wdata[0]) s_d.flag = 1'b0;
                end
                default: ;
            endcase
        end
        // a match outranks a clearing write in the same cycle
        if (match_i) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_DATA:  bus_rdata = s_q.data;
            ADR_CTRL:  bus_rdata[CTRL_W-1:0] = s_q.ctrl;
            ADR_FLAG:  bus_rdata[0] = s_q.flag;
            default:   bus_rdata = count_i;
        endcase
    end

    assign data_o = s_q.data;
    assign ctrl_o = s_q.ctrl;
    assign flag_o = s_q.flag;

endmodule

// File: rtl/bcit_step_sel.sv
module bcit_step_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic ext_evt,
    input  logic casc_tick_in,
    input  logic casc_wrap_in,
    input  logic casc_eq_in,
    input  logic ext_src,
    input  logic cascade,
    output logic step_o,
    output logic chk_o,
    output logic lo_eq_o
);

    typedef struct packed {
        logic ext_prev;
    } sel_t;

    sel_t s_d, s_q;
    logic own_step;

    always_comb begin
        s_d.ext_prev = ext_evt;
        own_step     = ext_src ? (ext_evt && !s_q.ext_prev) : tick_in;
        if (cascade) begin
            step_o  = casc_wrap_in;
            chk_o   = casc_tick_in;
            lo_eq_o = casc_eq_in;
        end else begin
            step_o  = own_step;
            chk_o   = own_step;
            lo_eq_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bcit_core.sv
module bcit_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         start_rise,
    input  logic         step,
    input  logic         chk,
    input  logic         lo_eq,
    input  logic [W-1:0] data,
    output logic [W-1:0] count_o,
    output logic [W-1:0] latch_o,
    output logic         match_o,
    output logic         wrap_o,
    output logic         eq_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] latch;
    } core_t;

    core_t s_d, s_q;
    logic  hit;

    always_comb begin
        s_d     = s_q;
        eq_o    = (s_q.count == s_q.latch);
        hit     = chk && lo_eq && eq_o;
        match_o = run && !start_rise && hit;
        wrap_o  = run && !start_rise && !hit && step && (s_q.count == CNT_MAX);
        if (start_rise) begin
            s_d.count = '0;
            s_d.latch = data;
        end else if (match_o) begin
            s_d.count = '0;
            s_d.latch = data;
        end else if (run && step) begin
            s_d.count = s_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
    assign latch_o = s_q.latch;

endmodule

// File: rtl/bcit_timer.sv
module bcit_timer
    import bcit_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              tick_in,
    input  logic              ext_evt,
    input  logic              casc_tick_in,
    input  logic              casc_wrap_in,
    input  logic              casc_eq_in,
    output logic              irq,
    output logic              eq_out,
    output logic              wrap_out
);

    logic [W-1:0] data_w;
    ctrl_t        ctrl_w;
    logic         flag_w;
    logic         start_rise_w;
    logic [W-1:0] count_w;
    logic [W-1:0] latch_w;
    logic         match_w;
    logic         step_w;
    logic         chk_w;
    logic         lo_eq_w;

    bcit_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .match_i      (match_w),
        .count_i      (count_w),
        .bus_rdata    (bus_rdata),
        .data_o       (data_w),
        .ctrl_o       (ctrl_w),
        .flag_o       (flag_w),
        .start_rise_o (start_rise_w)
    );

    bcit_step_sel u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_in      (tick_in),
        .ext_evt      (ext_evt),
        .casc_tick_in (casc_tick_in),
        .casc_wrap_in (casc_wrap_in),
        .casc_eq_in   (casc_eq_in),
        .ext_src      (ctrl_w.ext_src),
        .cascade      (ctrl_w.cascade),
        .step_o       (step_w),
        .chk_o        (chk_w),
        .lo_eq_o      (lo_eq_w)
    );

    bcit_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_w.run),
        .start_rise (start_rise_w),
        .step       (step_w),
        .chk        (chk_w),
        .lo_eq      (lo_eq_w),
        .data       (data_w),
        .count_o    (count_w),
        .latch_o    (latch_w),
        .match_o    (match_w),
        .wrap_o     (wrap_out),
        .eq_o       (eq_out)
    );

    assign irq = flag_w && ctrl_w.irq_en;

endmodule

// File: rtl/bcit_checker.sv
module bcit_checker
    import bcit_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_rise,
    input logic         match,
    input logic         wrap_out,
    input logic         casc_wrap_in,
    input ctrl_t        ctrl,
    input logic         flag,
    input logic [W-1:0] data,
    input logic [W-1:0] count,
    input logic [W-1:0] latch
);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> (count == '0 && latch == $past(data)));

    p_clear_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (count == '0 && flag));

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_rise && !match) |=> $stable(latch));

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !start_rise) |=> $stable(count));

    p_casc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cascade && ctrl.run && !start_rise && !match && !casc_wrap_in) |=> $stable(count));

    p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_out |=> (count == '0));

endmodule

bind bcit_timer bcit_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_rise   (start_rise_w),
    .match        (match_w),
    .wrap_out     (wrap_out),
    .casc_wrap_in (casc_wrap_in),
    .ctrl         (ctrl_w),
    .flag         (flag_w),
    .data         (data_w),
    .count        (count_w),
    .latch        (latch_w)
);

// File: tb/bcit_timer_test.sv
module bcit_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tick_in = 1'b0, ext_evt = 1'b0;
    logic       casc_tick_in = 1'b0, casc_wrap_in = 1'b0, casc_eq_in = 1'b0;
    logic       irq, eq_out, wrap_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcit_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_in(tick_in), .ext_evt(ext_evt), .casc_tick_in(casc_tick_in),
        .casc_wrap_in(casc_wrap_in), .casc_eq_in(casc_eq_in),
        .irq(irq), .eq_out(eq_out), .wrap_out(wrap_out)
    );

    // behavioural reference state
    int m_cnt, m_lat, m_data;
    bit m_run, m_src, m_casc, m_ie, m_flag, m_ext;

    function automatic void eval(output bit stp, output bit hit, output bit rise);
        bit wr, own;
        wr   = bus_sel && bus_wr;
        rise = wr && bus_addr == 2'd1 && bus_wdata[0] && !m_run;
        own  = m_src ? (ext_evt && !m_ext) : tick_in;
        if (m_casc) begin
            stp = casc_wrap_in;
            hit = casc_tick_in && casc_eq_in && (m_cnt == m_lat);
        end else begin
            stp = own;
            hit = own && (m_cnt == m_lat);
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_lat = 0; m_data = 0; m_run = 0; m_src = 0;
            m_casc = 0; m_ie = 0; m_flag = 0; m_ext = 0;
        end else begin
            bit stp, hit, rise, match;
            eval(stp, hit, rise);
            match = m_run && !rise && hit;
            if (rise) begin
                m_cnt = 0; m_lat = m_data;
            end else if (match) begin
                m_cnt = 0; m_lat = m_data;
            end else if (m_run && stp) begin
                m_cnt = (m_cnt + 1) % 256;
            end
            if (bus_sel && bus_wr) begin
                if (bus_addr == 2'd0) m_data = bus_wdata;
                if (bus_addr == 2'd1) begin
                    m_run = bus_wdata[0]; m_src = bus_wdata[1];
                    m_casc = bus_wdata[2]; m_ie = bus_wdata[3];
                end
                if (bus_addr == 2'd2 && !bus_wdata[0]) m_flag = 0;
            end
            if (match) m_flag = 1;
            m_ext = ext_evt;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit stp, hit, rise;
            int exp_rd;
            eval(stp, hit, rise);
            case (bus_addr)
                2'd0: exp_rd = m_data;
                2'd1: exp_rd = {m_ie, m_casc, m_src, m_run};
                2'd2: exp_rd = m_flag;
                default: exp_rd = m_cnt;
            endcase
            check(bus_rdata == exp_rd, "R10 readback", bus_rdata, exp_rd);
            check(eq_out == (m_cnt == m_lat), "R1 eq_out", eq_out, m_cnt == m_lat);
            check(irq == (m_flag && m_ie), "R7 irq", irq, m_flag && m_ie);
            check(wrap_out == (m_run && !rise && !hit && stp && m_cnt == 255),
                  "R9 wrap_out", wrap_out, m_run && !rise && !hit && stp && m_cnt == 255);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_addr = 2'd3;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1;
            @(negedge clk); tick_in = 0;
        end
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_evt = 1;
            @(negedge clk); ext_evt = 0;
        end
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk); bus_addr = a;
        #2 check(bus_rdata == exp, tag, bus_rdata, exp);
        bus_addr = 2'd3;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        rd(2'd1, 0, "R10 reset ctrl");
        rd(2'd2, 0, "R10 reset flag");
        rd(2'd3, 0, "R10 reset count");
        #1 check(irq == 0, "R10 reset irq", irq, 0);

        // R3 basic interval: latch 4 -> period 5
        wr(2'd0, 8'd4);
        wr(2'd1, 8'h01);
        rd(2'd3, 0, "R2 count cleared on start");
        tk(4);
        rd(2'd3, 4, "R1 count at latch");
        #1 check(eq_out == 1, "R1 eq at latch", eq_out, 1);
        tk(1);
        rd(2'd3, 0, "R3 clear after N+1 steps");
        rd(2'd2, 1, "R3 flag set on match");
        wr(2'd1, 8'h09);
        #1 check(irq == 1, "R7 irq with enable", irq, 1);

        // R4 buffered reload
        wr(2'd0, 8'd2);
        tk(2);
        #1 check(eq_out == 0, "R4 old latch kept", eq_out, 0);
        tk(3);
        rd(2'd3, 0, "R4 match on old value");
        tk(2);
        #1 check(eq_out == 1, "R4 new latch after match", eq_out, 1);

        // R7 flag write semantics
        wr(2'd2, 8'h01);
        rd(2'd2, 1, "R7 write 1 ignored");
        wr(2'd2, 8'h00);
        rd(2'd2, 0, "R7 write 0 clears");
        #1 check(irq == 0, "R7 irq drops", irq, 0);
        // match and clearing write together (count 2 == latch 2)
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h00; tick_in = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_addr = 2'd3; tick_in = 0;
        rd(2'd2, 1, "R7 set wins over clear");

        // R6 freeze
        tk(1);
        wr(2'd1, 8'h08);
        tk(3);
        rd(2'd3, 1, "R6 frozen count");

        // R2 start reload / no reload while running
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h09);
        tk(3);
        #1 check(eq_out == 1, "R2 latch loaded on start", eq_out, 1);
        wr(2'd0, 8'd6);
        wr(2'd1, 8'h09);
        rd(2'd3, 3, "R2 no clear when already running");
        #1 check(eq_out == 1, "R2 no reload when already running", eq_out, 1);

        // R5 external edges
        wr(2'd1, 8'h08);
        wr(2'd1, 8'h0B);
        @(negedge clk); ext_evt = 1;
        repeat (3) @(negedge clk);
        ext_evt = 0;
        rd(2'd3, 1, "R5 held level counts once");
        tk(2);
        rd(2'd3, 1, "R5 tick ignored in event mode");
        pulse_ext(2);
        rd(2'd3, 3, "R5 edges counted");

        // R8 cascade
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd1);
        wr(2'd1, 8'h05);
        tk(2);
        rd(2'd3, 0, "R8 own tick ignored");
        @(negedge clk); casc_wrap_in = 1;
        @(negedge clk); casc_wrap_in = 0;
        rd(2'd3, 1, "R8 steps on lower wrap");
        @(negedge clk); casc_tick_in = 1; casc_eq_in = 0;
        @(negedge clk); casc_tick_in = 0;
        rd(2'd2, 0, "R8 no match without lower equal");
        @(negedge clk); casc_tick_in = 1; casc_eq_in = 1;
        @(negedge clk); casc_tick_in = 0; casc_eq_in = 0;
        rd(2'd3, 0, "R8 match clears");
        rd(2'd2, 1, "R8 match sets flag");

        // R9 wrap
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd255);
        wr(2'd1, 8'h05);
        for (int i = 0; i < 255; i++) begin
            @(negedge clk); casc_wrap_in = 1;
            @(negedge clk); casc_wrap_in = 0;
        end
        rd(2'd3, 255, "R9 count at max");
        @(negedge clk); casc_wrap_in = 1; casc_tick_in = 1; casc_eq_in = 0;
        #2 check(wrap_out == 1, "R9 wrap pulse", wrap_out, 1);
        @(negedge clk); casc_wrap_in = 0; casc_tick_in = 0;
        rd(2'd3, 0, "R9 count wrapped");
        rd(2'd2, 0, "R9 no flag on wrap");

        // R10 map and read-only count
        rd(2'd0, 255, "R10 data readback");
        wr(2'd3, 8'd7);
        rd(2'd3, 0, "R10 count write ignored");

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule